// File: doc/BRIEF.md
# DRAM Power-Up and CAS-Before-RAS Refresh Scheduler

This block sits next to the access sequencer of an asynchronous DRAM that takes its address in two halves. After reset it keeps the strobes idle for a programmable pause. It then runs a fixed burst of warm-up refreshes and raises `ready_o`, which admits host traffic. After that it keeps the array refreshed. A timer marks each refresh slot. Each slot adds one to a small counter of owed refreshes. Every owed refresh is run as a CAS-before-RAS cycle on the block's own strobe outputs. That refresh ordering lets the DRAM pick the row, so the block keeps no row address.

The host sequencer asks to open an access with `host_req_i` and may start only when `host_gnt_o` is high. It reports that its own RAS is held low through `host_ras_act_i`. An owed refresh waits until the host lets RAS go. It then wins over any new host request. Slots that pass while the host holds RAS are stored up to a parameter limit and run back to back. All times are counted in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ras_n_o` and both bits of `cas_n_o` stay high and `ready_o` stays low for at least `PWRUP_CYC` cycles.
- R2: Exactly `WARMUP_REFS` refresh cycles run before `ready_o` rises. No host grant is given while `ready_o` is low.
- R3: Once `ready_o` is high it stays high until the next reset.
- R4: Every refresh drives both bits of `cas_n_o` low exactly `T_CSR` cycles before `ras_n_o` falls. The two bits of `cas_n_o` are always equal.
- R5: In a refresh, `ras_n_o` stays low for exactly `T_RAS` cycles. It rises in the same cycle as `cas_n_o`. Both strobes then stay high for at least `T_RP` cycles before the next refresh starts.
- R6: With `ready_o` high and no host traffic, exactly one refresh starts every `REF_INT_CYC` cycles.
- R7: A refresh never drives `ras_n_o` low while `host_ras_act_i` is high. A refresh that is owed waits for the host to release RAS.
- R8: `host_gnt_o` is high only when `host_req_i` is high, `ready_o` is high, no refresh is owed or running, and `host_ras_act_i` is low.
- R9: Refresh slots that pass while the host holds RAS are counted up to `MAX_OWED` and run back to back once RAS is released. Slots beyond `MAX_OWED` are dropped.
- R10: While `rst_ni` is low: `ras_n_o`=1, `cas_n_o`=2'b11, `ready_o`=0 and `host_gnt_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host asks to open an access |
| host_ras_act_i | input | 1 | Host sequencer holds its RAS low |
| host_gnt_o | output | 1 | Host may open its access |
| ready_o | output | 1 | Power-up and warm-up are complete |
| ras_n_o | output | 1 | Refresh row strobe, active low |
| cas_n_o | output | 2 | Upper and lower column strobes for refresh, active low |

## Verification
The assertions assume the host obeys the grant. It raises `host_ras_act_i` only in the cycle after it sees `host_gnt_o`, and it never holds it high without a grant. Without that rule, the check that refresh and host RAS never overlap could fail on a correct design. The bench host model follows this rule: it samples the grant at the falling edge and raises its RAS flag before the next rising edge. The random access lengths are kept shorter than one refresh interval, so no slot is dropped. Long holds are made only in the directed make-up cases, and each starts right after an observed refresh, so the number of slots that pass is known.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {PH_PWRUP, PH_WARM, PH_RUN} init_ph_e;
  typedef enum logic [1:0] {CY_IDLE, CY_CAS, CY_RAS, CY_PRE} cyc_st_e;
endpackage

// File: rtl/ref_init_timer.sv
module ref_init_timer #(
  parameter int PWRUP_CYC   = 25000,
  parameter int REF_INT_CYC = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic pause_done_o,
  output logic tick_o
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int IW = $clog2(REF_INT_CYC + 1);

  logic [PW-1:0] pause_q;
  logic          pause_done_q;
  logic [IW-1:0] int_q;
  logic          int_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_q      <= '0;
      pause_done_q <= 1'b0;
    end else if (!pause_done_q) begin
      if (pause_q == PW'(PWRUP_CYC - 1)) pause_done_q <= 1'b1;
      else                               pause_q      <= pause_q + 1'b1;
    end
  end

  assign int_wrap = (int_q == IW'(REF_INT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       int_q <= '0;
    else if (!run_i)   int_q <= '0;
    else if (int_wrap) int_q <= '0;
    else               int_q <= int_q + 1'b1;
  end

  assign pause_done_o = pause_done_q;
  assign tick_o       = run_i && int_wrap;

  // R6
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ref_owed_ctr.sv
module ref_owed_ctr #(
  parameter int MAX_OWED = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pend_o
);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [OW-1:0] cnt_q;
  logic          full;

  assign full = (cnt_q == OW'(MAX_OWED));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && !full) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)          cnt_q <= cnt_q - 1'b1;
  end

  assign pend_o = (cnt_q != '0);

  // R9
  owed_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && full) |=> full);
  // R9
  owed_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> pend_o);
endmodule

// File: rtl/cbr_strobe_gen.sv
module cbr_strobe_gen
  import dram_ref_pkg::*;
#(
  parameter int T_CSR = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       idle_o,
  output logic       done_o,
  output logic       ras_n_o,
  output logic [1:0] cas_n_o
);
  localparam int TMAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                        : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int CW = $clog2(TMAX + 1);

  cyc_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  always_comb begin
    unique case (st_q)
      CY_CAS:  last = (cnt_q == CW'(T_CSR - 1));
      CY_RAS:  last = (cnt_q == CW'(T_RAS - 1));
      CY_PRE:  last = (cnt_q == CW'(T_RP - 1));
      default: last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CY_IDLE;
      cnt_q <= '0;
    end else begin
      cnt_q <= last ? '0 : ((st_q == CY_IDLE) ? '0 : cnt_q + 1'b1);
      unique case (st_q)
        CY_IDLE: if (start_i) st_q <= CY_CAS;
        CY_CAS:  if (last)    st_q <= CY_RAS;
        CY_RAS:  if (last)    st_q <= CY_PRE;
        default: if (last)    st_q <= CY_IDLE;
      endcase
    end
  end

  assign idle_o  = (st_q == CY_IDLE);
  assign done_o  = (st_q == CY_PRE) && last;
  assign ras_n_o = (st_q != CY_RAS);
  // both byte strobes move together during refresh
  assign cas_n_o = {2{(st_q != CY_CAS) && (st_q != CY_RAS)}};

  // R4
  cbr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (cas_n_o == 2'b00));
  // R5
  ras_cas_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (cas_n_o == 2'b11));
  // R7
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> idle_o);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int PWRUP_CYC   = 25000,
  parameter int REF_INT_CYC = 1950,
  parameter int WARMUP_REFS = 8,
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 6,
  parameter int T_RP        = 5,
  parameter int MAX_OWED    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_req_i,
  input  logic       host_ras_act_i,
  output logic       host_gnt_o,
  output logic       ready_o,
  output logic       ras_n_o,
  output logic [1:0] cas_n_o
);
  localparam int WW = $clog2(WARMUP_REFS + 1);

  init_ph_e      ph_q;
  logic [WW-1:0] warm_q;
  logic          pause_done, tick, pend, idle, done, need, start, run;

  assign run = (ph_q == PH_RUN);

  ref_init_timer #(.PWRUP_CYC(PWRUP_CYC), .REF_INT_CYC(REF_INT_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .pause_done_o(pause_done), .tick_o(tick));

  ref_owed_ctr #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk_i, .rst_ni, .inc_i(tick), .dec_i(start && run), .pend_o(pend));

  cbr_strobe_gen #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_strobe (
    .clk_i, .rst_ni, .start_i(start), .idle_o(idle), .done_o(done),
    .ras_n_o, .cas_n_o);

  assign need  = ((ph_q == PH_WARM) && (warm_q != '0)) || (run && pend);
  assign start = need && idle && !host_ras_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_PWRUP;
      warm_q <= WW'(WARMUP_REFS);
    end else begin
      unique case (ph_q)
        PH_PWRUP: if (pause_done) ph_q <= PH_WARM;
        PH_WARM: begin
          if (start) warm_q <= warm_q - 1'b1;
          if (done && warm_q == '0) ph_q <= PH_RUN;
        end
        default: ;
      endcase
    end
  end

  assign ready_o    = run;
  assign host_gnt_o = run && host_req_i && idle && !pend && !host_ras_act_i;

  // R1
  pwrup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_PWRUP) |-> (ras_n_o && cas_n_o == 2'b11 && !ready_o));
  // R2
  warm_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (warm_q == '0));
  // R3
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R8
  gnt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> (ready_o && ras_n_o && cas_n_o == 2'b11));
  // R7
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !host_ras_act_i);
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int PWRUP = 300, INTV = 100, WARM = 8;
  localparam int TCSR = 2, TRAS = 5, TRP = 3, MAXO = 3;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, act = 1'b0;
  logic gnt, ready, ras_n;
  logic [1:0] cas_n;

  always #4 clk = ~clk;

  dram_refresh_sched #(.PWRUP_CYC(PWRUP), .REF_INT_CYC(INTV), .WARMUP_REFS(WARM),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .MAX_OWED(MAXO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(req), .host_ras_act_i(act),
    .host_gnt_o(gnt), .ready_o(ready), .ras_n_o(ras_n), .cas_n_o(cas_n));

  int total = 0, bad = 0;
  int cyc = 0, ref_cnt = 0, first_act = -1, ready_cyc = -1, refs_at_ready = -1;
  int cas_fall_cyc = 0, ras_fall_cyc = 0, ras_rise_cyc = -1000;
  logic prev_ras = 1'b1;
  logic [1:0] prev_cas = 2'b11;

  task automatic chk(input bit ok, input string req_tag, input int actv, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, actv, expv);
    end
  endtask

  function automatic int exp_makeup(input int slots);
    return (slots > MAXO) ? MAXO : slots;
  endfunction

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cas_n[0] != cas_n[1]) chk(0, "R4 split", cas_n, 0);
      if (cas_n == 2'b00 && prev_cas == 2'b11) begin
        cas_fall_cyc = cyc;
        if (first_act < 0) first_act = cyc;
        if (ref_cnt > 0) chk(cyc - ras_rise_cyc >= TRP, "R5 precharge", cyc - ras_rise_cyc, TRP);
      end
      if (!ras_n && prev_ras) begin
        ref_cnt++;
        ras_fall_cyc = cyc;
        chk(cas_n == 2'b00 && cyc - cas_fall_cyc == TCSR, "R4 setup", cyc - cas_fall_cyc, TCSR);
      end
      if (ras_n && !prev_ras) begin
        ras_rise_cyc = cyc;
        chk(cyc - ras_fall_cyc == TRAS && cas_n == 2'b11, "R5 width", cyc - ras_fall_cyc, TRAS);
      end
      if (!ras_n && act) chk(0, "R7 overlap", 1, 0);
      if (gnt && !ready) chk(0, "R2 early grant", 1, 0);
      if (gnt && !req) chk(0, "R8 grant without request", 1, 0);
      if (ready && ready_cyc < 0) begin
        ready_cyc = cyc;
        refs_at_ready = ref_cnt;
      end
      if (!ready && ready_cyc >= 0) chk(0, "R3 ready drop", 0, 1);
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic wait_ref();
    int c = ref_cnt;
    while (ref_cnt == c) @(negedge clk);
  endtask

  task automatic host_access(input int len);
    req = 1'b1;
    @(negedge clk);
    while (!gnt) @(negedge clk);
    act = 1'b1;
    req = 1'b0;
    repeat (len) @(negedge clk);
    act = 1'b0;
  endtask

  task automatic makeup_case(input int slots);
    int r0;
    wait_ref();
    host_access(slots * INTV + 20);
    r0 = ref_cnt;
    req = 1'b1;
    @(negedge clk);
    while (!gnt) @(negedge clk);
    // R9 and R8: burst ran before the host got back in
    chk(ref_cnt - r0 == exp_makeup(slots), "R9 makeup", ref_cnt - r0, exp_makeup(slots));
    act = 1'b1;
    req = 1'b0;
    repeat (3) @(negedge clk);
    act = 1'b0;
  endtask

  bit fin = 1'b0;

  initial begin
    int r0, c0, lo, hi;
    void'($urandom(32'h1d2e));
    repeat (5) @(negedge clk);
    // R10
    chk(ras_n == 1'b1 && cas_n == 2'b11, "R10 strobes", {ras_n, cas_n}, 3'b111);
    chk(!ready && !gnt, "R10 ready/gnt", {ready, gnt}, 0);
    rst_n = 1'b1;
    req = 1'b1; // a request during power-up must not be granted (R2)
    while (ready_cyc < 0) @(negedge clk);
    req = 1'b0;
    // R1
    chk(first_act >= PWRUP, "R1 pause", first_act, PWRUP);
    // R2
    chk(refs_at_ready == WARM, "R2 warmup", refs_at_ready, WARM);
    // R6 steady rate
    wait_ref();
    r0 = ref_cnt;
    repeat (10 * INTV + INTV / 2) @(negedge clk);
    chk(ref_cnt - r0 == 10, "R6 rate", ref_cnt - r0, 10);
    // R9 and R7 directed
    makeup_case(2);
    makeup_case(5);
    makeup_case(1);
    // R8: grant comes only while idle with nothing owed
    wait_ref();
    req = 1'b1;
    @(negedge clk);
    chk(!gnt, "R8 gnt during refresh", gnt, 0);
    while (!gnt) @(negedge clk);
    chk(ras_n && cas_n == 2'b11, "R8 gnt idle", {ras_n, cas_n}, 3'b111);
    req = 1'b0;
    // random host traffic
    r0 = ref_cnt;
    c0 = cyc;
    for (int i = 0; i < 40; i++) begin
      host_access(1 + $urandom_range(0, 59));
      repeat ($urandom_range(0, 15)) @(negedge clk);
    end
    lo = (cyc - c0) / INTV - 1;
    hi = (cyc - c0) / INTV + 1;
    chk(ref_cnt - r0 >= lo && ref_cnt - r0 <= hi, "R6 rate under traffic", ref_cnt - r0, lo + 1);
    chk(ready, "R3 ready held", ready, 1);
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      chk(0, "R6 watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule